// File: doc/BRIEF.md
# Interlaced Pair Left-Neighbour Column Buffer

This block keeps, for one macroblock pair, the most recently reconstructed pixel to the left of every picture line the pair covers (32 lines of 8-bit samples). Each time a 4x4 block finishes, its rightmost column of four pixels is written into the buffer. The buffer therefore sweeps from left to right across the pair. When the pair is complete, it already holds exactly the column that the next pair to the right needs as its left neighbours.

Storage is indexed by physical line within the pair, not by line within a macroblock. In frame mode, a block row of the upper macroblock covers four consecutive lines in the upper half, and a block row of the lower macroblock covers four consecutive lines in the lower half. In field mode, the upper macroblock owns the even lines and the lower macroblock owns the odd lines. Its writes therefore land in every second slot. Because the data is rearranged as it is written, the read side derives the four neighbour lines from the current pair's mode alone and never needs the previous pair's mode.

A row-start pulse clears the whole column and marks every line unavailable, as at the left picture edge. The neighbour output is combinational from the stored state. An availability flag reports whether all four selected lines have been written since the last clear.

Top module: `lnb_left_buf`

## Requirements
- R1: After reset, every line is cleared to zero and marked unavailable, so `nbr_pix` reads 0 and `nbr_avail` reads 0 for any selection.
- R2: In frame mode with `mb_bot`=0, a write for block row r stores `col_pix` byte i (bits 8i+7:8i, i=0 the top pixel) into pair line 4r+i.
- R3: In frame mode with `mb_bot`=1, a write for block row r stores byte i into pair line 16+4r+i.
- R4: In field mode with `mb_bot`=0, a write for block row r stores byte i into even pair line 8r+2i, leaving the odd lines untouched.
- R5: In field mode with `mb_bot`=1, a write for block row r stores byte i into odd pair line 8r+2i+1, leaving the even lines untouched.
- R6: `nbr_pix` byte i is the stored pixel of the pair line that the R2 to R5 mapping gives for the current `blk_row`, `mb_bot` and `pair_field`, regardless of the mode in which that line was written.
- R7: A later write to a line replaces its earlier content.
- R8: A `row_start` pulse clears every line to zero and marks it unavailable from the next cycle on.
- R9: When `row_start` and `blk_done` are high in the same cycle, the clear wins and the write is dropped.
- R10: `nbr_avail` is 1 only when all four selected lines have been written since the last reset or clear.
- R11: A write becomes visible on `nbr_pix` in the cycle after `blk_done`. Without a write or clear, the output changes only when the selection inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_start | input | 1 | Clear pulse at the start of a picture row of pairs |
| blk_done | input | 1 | Strobe: a 4x4 block has been reconstructed |
| blk_row | input | 2 | Block row (0 to 3) inside the current macroblock |
| mb_bot | input | 1 | 0 for the upper macroblock of the pair, 1 for the lower |
| pair_field | input | 1 | 0 for frame-coded pair, 1 for field-coded pair |
| col_pix | input | 32 | Right column of the finished block, byte i is row i |
| nbr_pix | output | 32 | Left neighbours of the selected block, byte i is row i |
| nbr_avail | output | 1 | All four selected neighbours are valid |

## Verification
The stimulus writes columns in frame mode into both halves, then in field mode into both parities over the same lines. It then reads them back under the other mode. A mis-mapped line or a wrong parity shows up as a byte that lands in the wrong lane. Field writes read in frame mode must interleave two sources byte by byte, which separates the even-line and odd-line paths. Partial coverage, where a field write leaves odd lines empty, distinguishes a per-line valid flag from a single global one. A clear that coincides with a write shows whether the clear takes priority.

// File: rtl/lnb_pkg.sv
// Package: shared defaults and the pair coding mode encoding for the
// left-neighbour column buffer. Assumes one sample per byte lane.
package lnb_pkg;
    localparam int PIX_W_DEF = 8;   // bits per sample
    localparam int MB_H_DEF  = 16;  // lines per macroblock
    localparam int BLK_DEF   = 4;   // block edge in samples

    typedef enum logic {
        PAIR_FRAME = 1'b0,
        PAIR_FIELD = 1'b1
    } pair_mode_e;
endpackage

// File: rtl/lnb_row_map.sv
// Module: lnb_row_map
// Turns (block row, upper/lower macroblock, pair mode) into the physical
// pair line of each of the BLK lanes. Frame mode stacks the macroblocks,
// field mode interleaves them by line parity. Purely combinational.
module lnb_row_map #(
    parameter int MB_H = lnb_pkg::MB_H_DEF,
    parameter int BLK  = lnb_pkg::BLK_DEF,
    localparam int ROWS = 2 * MB_H,
    localparam int RW   = $clog2(ROWS),
    localparam int BRW  = $clog2(MB_H / BLK)
) (
    input  logic                    pair_field,
    input  logic                    mb_bot,
    input  logic [BRW-1:0]          blk_row,
    output logic [BLK-1:0][RW-1:0]  lines
);
    import lnb_pkg::*;

    for (genvar l = 0; l < BLK; l++) begin : g_lane
        // Line inside the macroblock that this lane covers.
        localparam int LANE = l;
        logic [31:0] in_mb;
        assign in_mb = 32'(int'(blk_row) * BLK + LANE);

        // Pick stacked or interleaved placement from the pair mode.
        always_comb begin
            if (pair_mode_e'(pair_field) == PAIR_FIELD)
                lines[l] = RW'(in_mb * 2 + 32'(mb_bot));
            else
                lines[l] = RW'(32'(mb_bot) * MB_H + in_mb);
        end
    end
endmodule

// File: rtl/lnb_store.sv
// Module: lnb_store
// One sample and one valid flag per pair line. LANES lines are written
// at once (the lines must be distinct) and LANES lines are read
// combinationally. Clear has priority over write. Synchronous reset.
module lnb_store #(
    parameter int ROWS  = 32,
    parameter int PIX_W = lnb_pkg::PIX_W_DEF,
    parameter int LANES = lnb_pkg::BLK_DEF,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       we,
    input  logic [LANES-1:0][RW-1:0]   lines,
    input  logic [LANES-1:0][PIX_W-1:0] wr_pix,
    output logic [LANES-1:0][PIX_W-1:0] rd_pix,
    output logic [LANES-1:0]           rd_ok
);
    logic [PIX_W-1:0] mem [ROWS];
    logic [ROWS-1:0]  vld;

    // Storage update: reset/clear empties everything, else write lanes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
            vld <= '0;
        end else if (we) begin
            for (int l = 0; l < LANES; l++) begin
                mem[lines[l]] <= wr_pix[l];
                vld[lines[l]] <= 1'b1;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        // Combinational read of one selected line.
        assign rd_pix[l] = mem[lines[l]];
        assign rd_ok[l]  = vld[lines[l]];
    end
endmodule

// File: rtl/lnb_left_buf.sv
// Module: lnb_left_buf (top)
// Left-neighbour column buffer for one macroblock pair. The same selection
// inputs address the write of a finished block's right column and the
// read of the current block's left neighbours; the read shows the state
// before any write in the same cycle. Assumes blk_done is a single-cycle
// strobe and that row_start precedes the first pair of a picture row.
module lnb_left_buf #(
    parameter int PIX_W = lnb_pkg::PIX_W_DEF,
    parameter int MB_H  = lnb_pkg::MB_H_DEF,
    parameter int BLK   = lnb_pkg::BLK_DEF,
    localparam int ROWS = 2 * MB_H,
    localparam int RW   = $clog2(ROWS),
    localparam int BRW  = $clog2(MB_H / BLK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   row_start,
    input  logic                   blk_done,
    input  logic [BRW-1:0]         blk_row,
    input  logic                   mb_bot,
    input  logic                   pair_field,
    input  logic [BLK*PIX_W-1:0]   col_pix,
    output logic [BLK*PIX_W-1:0]   nbr_pix,
    output logic                   nbr_avail
);
    logic [BLK-1:0][RW-1:0]    sel_lines;
    logic [BLK-1:0][PIX_W-1:0] wr_lanes;
    logic [BLK-1:0][PIX_W-1:0] rd_lanes;
    logic [BLK-1:0]            rd_ok;

    // Lane view of the incoming column and of the outgoing neighbours.
    assign wr_lanes  = col_pix;
    assign nbr_pix   = rd_lanes;
    assign nbr_avail = &rd_ok;

    lnb_row_map #(.MB_H(MB_H), .BLK(BLK)) map_i (
        .pair_field (pair_field),
        .mb_bot     (mb_bot),
        .blk_row    (blk_row),
        .lines      (sel_lines)
    );

    lnb_store #(.ROWS(ROWS), .PIX_W(PIX_W), .LANES(BLK)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (row_start),
        .we     (blk_done),
        .lines  (sel_lines),
        .wr_pix (wr_lanes),
        .rd_pix (rd_lanes),
        .rd_ok  (rd_ok)
    );
endmodule

// File: rtl/lnb_left_buf_chk.sv
// Module: lnb_left_buf_chk
// Port-level temporal checks for lnb_left_buf, attached by bind.
module lnb_left_buf_chk #(
    parameter int PIX_W = lnb_pkg::PIX_W_DEF,
    parameter int BLK   = lnb_pkg::BLK_DEF,
    parameter int BRW   = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 row_start,
    input logic                 blk_done,
    input logic [BRW-1:0]       blk_row,
    input logic                 mb_bot,
    input logic                 pair_field,
    input logic [BLK*PIX_W-1:0] col_pix,
    input logic [BLK*PIX_W-1:0] nbr_pix,
    input logic                 nbr_avail
);
    // Leaving reset shows an empty, unavailable column.
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!nbr_avail && nbr_pix == '0));

    // A clear (even together with a write) empties the column next cycle.
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> (!nbr_avail && nbr_pix == '0));

    // A write is read back unchanged next cycle under the same selection.
    assert_write_visible_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !row_start) |=>
        (!($stable(blk_row) && $stable(mb_bot) && $stable(pair_field))
         || (nbr_avail && nbr_pix == $past(col_pix))));

    // With no write, no clear and a fixed selection, the output holds.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_done && !row_start) |=>
        (!($stable(blk_row) && $stable(mb_bot) && $stable(pair_field))
         || ($stable(nbr_pix) && $stable(nbr_avail))));

    // Availability only appears through a write or a new selection.
    assert_avail_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nbr_avail) |->
        ($past(blk_done) || !$stable(blk_row) || !$stable(mb_bot)
         || !$stable(pair_field)));
endmodule

bind lnb_left_buf lnb_left_buf_chk #(.PIX_W(PIX_W), .BLK(BLK), .BRW(BRW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_start  (row_start),
    .blk_done   (blk_done),
    .blk_row    (blk_row),
    .mb_bot     (mb_bot),
    .pair_field (pair_field),
    .col_pix    (col_pix),
    .nbr_pix    (nbr_pix),
    .nbr_avail  (nbr_avail)
);

// File: tb/lnb_left_buf_tb_top.sv
// Bench for lnb_left_buf: a vector table walked once, then directed
// reset checks. Inputs change at the falling edge, outputs are sampled
// 5 ns later, before the next rising edge applies any write or clear.
module lnb_left_buf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_start = 1'b0;
    logic        blk_done = 1'b0;
    logic [1:0]  blk_row = '0;
    logic        mb_bot = 1'b0;
    logic        pair_field = 1'b0;
    logic [31:0] col_pix = '0;
    logic [31:0] nbr_pix;
    logic        nbr_avail;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    lnb_left_buf dut_i (
        .clk(clk), .rst_n(rst_n), .row_start(row_start), .blk_done(blk_done),
        .blk_row(blk_row), .mb_bot(mb_bot), .pair_field(pair_field),
        .col_pix(col_pix), .nbr_pix(nbr_pix), .nbr_avail(nbr_avail)
    );

    typedef struct packed {
        logic [15:0] tag;   // requirement name as two ASCII characters
        logic        rs;
        logic        dn;
        logic [1:0]  br;
        logic        bot;
        logic        fld;
        logic [31:0] pix;
        logic [31:0] exp_pix;  // expected before this vector's clock edge
        logic        exp_av;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{"R1", 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 32'h13121110, 32'h00000000, 1'b0},
        '{"R2", 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,        32'h13121110, 1'b1},
        '{"R3", 1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 32'h2F2E2D2C, 32'h00000000, 1'b0},
        '{"R3", 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 32'h0,        32'h2F2E2D2C, 1'b1},
        '{"R6", 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 32'hA3A2A1A0, 32'h00001210, 1'b0},
        '{"R4", 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,        32'h13A111A0, 1'b1},
        '{"R6", 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 32'hB3B2B1B0, 32'h00001311, 1'b0},
        '{"R5", 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0,        32'hB3A3B2A2, 1'b1},
        '{"R7", 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,        32'hB1A1B0A0, 1'b1},
        '{"R11", 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 32'hC3C2C1C0, 32'hB1A1B0A0, 1'b1},
        '{"R7", 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0,        32'hA3A2C2C0, 1'b1},
        '{"R9", 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h2F2E2D2C, 1'b1},
        '{"R9", 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 32'h0,        32'h00000000, 1'b0},
        '{"R8", 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,        32'h00000000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic rs, input logic dn, input logic [1:0] br,
                         input logic bot, input logic fld, input logic [31:0] pix);
        row_start = rs; blk_done = dn; blk_row = br;
        mb_bot = bot; pair_field = fld; col_pix = pix;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R1 pix", nbr_pix, 32'h0);
        chk("R1 avail", {31'b0, nbr_avail}, 32'h0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            drive(VEC[v].rs, VEC[v].dn, VEC[v].br, VEC[v].bot, VEC[v].fld, VEC[v].pix);
            #5;
            chk($sformatf("%s pix vec%0d", VEC[v].tag, v), nbr_pix, VEC[v].exp_pix);
            chk($sformatf("%s avail vec%0d", VEC[v].tag, v), {31'b0, nbr_avail},
                {31'b0, VEC[v].exp_av});
        end

        // R11: combinational read follows the selection with no clock edge
        @(negedge clk);
        drive(1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 32'h5A5B5C5D);
        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
        #2;
        chk("R11 other selection", nbr_pix, 32'h0);
        blk_row = 2'd2; mb_bot = 1'b1;
        #2;
        chk("R11 selection change", nbr_pix, 32'h5A5B5C5D);

        // R1: reset in mid-run empties the column again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R1 mid-run pix", nbr_pix, 32'h0);
        chk("R1 mid-run avail", {31'b0, nbr_avail}, 32'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule